// File: doc/BRIEF.md
# Drive Power Sequencing Controller

This block sits on the control side of an inverter drive and decides when the PWM gate signals may reach the power stage. It watches three readiness inputs: the control supply is up, the gate-driver supply is no longer in undervoltage, and the DC-link precharge relay reports that it is closed. Only when all three hold together does it pulse the power stage's fault-latch reset. PWM is enabled only after that pulse has run its full length.

While the drive runs, the controller keeps watching the relay feedback and the bus-ripple status line. If the relay drops out, PWM enable falls in the same cycle and the controller goes back to waiting for readiness, so a new reset pulse is needed. Repeated toggling of the ripple line inside a time window means an input phase is missing. In that case PWM is inhibited and a sticky fault is raised. Another sticky fault is raised if precharge does not finish within its time budget. A stop request runs an orderly shutdown: it asks the speed loop for zero speed, waits for the acknowledge, removes PWM, and then signals that main power may be disconnected.

All times are given in real units (clock rate in kHz, pulse width in microseconds, precharge budget in milliseconds) and converted to cycle counts when the block is built. An optional synchroniser can be placed on the status inputs.

Top module: `drv_seq_ctrl`

## Requirements
- R1: After reset, latch_rst, pwm_en, zero_req, mains_release, fault_precharge and fault_phase are all low.
- R2: After a start request is accepted, latch_rst rises one cycle after supply_ok=1, uv_flag=0 and relay_fb=1 are seen in the same cycle. While any one of the three is missing, latch_rst stays low.
- R3: latch_rst stays high for exactly ceil(CLK_KHZ*RST_US/1000) cycles. In the cycle after the last of these, latch_rst is low and pwm_en is high. pwm_en is never high before a complete pulse.
- R4: If any readiness condition is lost during the pulse, latch_rst falls one cycle later and pwm_en stays low. A fresh full-length pulse follows once all three conditions hold again.
- R5: While running, relay_fb=0 forces pwm_en low in that same cycle. The controller then waits for readiness again and issues a new reset pulse before re-enabling PWM.
- R6: If readiness is not reached within CLK_KHZ*PRECHG_MS cycles of an accepted start, fault_precharge is set and pwm_en and latch_rst stay low.
- R7: While the controller is out of idle, PH_EDGES transitions of ripple inside one PH_WIN_CYC-cycle window set fault_phase and drop pwm_en one cycle after the last transition.
- R8: Fewer than PH_EDGES ripple transitions per window cause no fault, and pwm_en stays high.
- R9: A stop request while running raises zero_req one cycle later, with pwm_en still high. One cycle after zero_ack=1, pwm_en and zero_req are low. mains_release rises one cycle after that and stays high until the next accepted start, when it falls in the following cycle.
- R10: While either fault flag is set, start requests are ignored. fault_clr clears both flags.
- R11: A stop request while waiting for readiness returns the controller to idle without a reset pulse and without raising mains_release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Request to bring the drive up (one-cycle pulse or level) |
| stop_req | input | 1 | Request for an orderly stop |
| fault_clr | input | 1 | Clears the sticky fault flags |
| supply_ok | input | 1 | Control supply established |
| uv_flag | input | 1 | Gate-driver supply undervoltage, high while low voltage |
| relay_fb | input | 1 | Precharge relay energised feedback |
| ripple | input | 1 | Bus ripple status, high while relay open |
| zero_ack | input | 1 | Speed loop reports zero speed reached |
| latch_rst | output | 1 | Reset pulse to the power stage fault latch |
| pwm_en | output | 1 | Permission for PWM signals to reach the power stage |
| zero_req | output | 1 | Request to the speed loop to bring speed to zero |
| mains_release | output | 1 | Main power may be disconnected |
| fault_precharge | output | 1 | Sticky precharge timeout fault |
| fault_phase | output | 1 | Sticky input phase loss fault |

## Verification
The bench builds the block with a 1000 kHz clock and a 3 µs pulse, so the pulse is three cycles long and every cycle of it can be checked. A 1 ms precharge budget gives a 1000-cycle timeout, which keeps the timeout path short enough to run. Phase loss is tested with a 4-edge threshold in a 64-cycle window, so both a burst that trips the fault and bursts that stay below the threshold across window boundaries can be driven directly. The synchroniser depth is set to zero, so each readiness change has a known one-cycle effect on the outputs.

// File: rtl/drv_seq_pkg.sv
package drv_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_WAIT  = 3'd1,
      ST_PULSE = 3'd2,
      ST_RUN   = 3'd3,
      ST_STOP  = 3'd4
   } seq_state_t;

   // Counter width able to hold values 0 .. n-1 (at least one bit)
   function automatic int cnt_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/drv_seq_sync.sv
module drv_seq_sync #(
   parameter int           W       = 1,
   parameter int           STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 0) begin : g_bad_stages
         $error("drv_seq_sync: STAGES must not be negative");
      end

      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] chain [STAGES];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int k = 0; k < STAGES; k++) chain[k] <= RST_VAL;
            end else begin
               chain[0] <= d;
               for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
            end
         end

         assign q = chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/drv_seq_timer.sv
module drv_seq_timer
   import drv_seq_pkg::*;
#(
   parameter int LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic expire
);

   localparam int CW = cnt_width(LIMIT);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("drv_seq_timer: LIMIT must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!en) begin
         cnt_q <= '0;
      end else if (cnt_q == LAST) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expire = en && (cnt_q == LAST);

   // The running count never leaves its interval (R3, R6)
   assert_timer_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

   // A disabled timer restarts from zero (R6)
   assert_timer_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en) |-> cnt_q == '0);

endmodule

// File: rtl/drv_seq_phase_mon.sv
module drv_seq_phase_mon
   import drv_seq_pkg::*;
#(
   parameter int EDGES   = 6,
   parameter int WIN_CYC = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic ripple,
   output logic phase_lost
);

   localparam int WW = cnt_width(WIN_CYC);
   localparam int EW = cnt_width(EDGES);
   localparam logic [WW-1:0] WIN_LAST  = WW'(WIN_CYC - 1);
   localparam logic [EW-1:0] EDGE_LAST = EW'(EDGES - 1);

   generate
      if (EDGES < 2) begin : g_bad_edges
         $error("drv_seq_phase_mon: EDGES must be at least 2");
      end
      if (WIN_CYC < EDGES) begin : g_bad_win
         $error("drv_seq_phase_mon: window shorter than edge threshold");
      end
   endgenerate

   logic          rip_q;
   logic [WW-1:0] win_q;
   logic [EW-1:0] edg_q;
   logic          toggled;
   logic          win_end;

   assign toggled = ripple ^ rip_q;
   assign win_end = (win_q == WIN_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rip_q <= 1'b1;
      end else begin
         rip_q <= ripple;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q <= '0;
         edg_q <= '0;
      end else if (!active) begin
         win_q <= '0;
         edg_q <= '0;
      end else if (win_end) begin
         win_q <= '0;
         edg_q <= '0;
      end else begin
         win_q <= win_q + 1'b1;
         if (toggled && (edg_q != EDGE_LAST)) edg_q <= edg_q + 1'b1;
      end
   end

   assign phase_lost = active && toggled && !win_end && (edg_q == EDGE_LAST);

   // Edge tally stays below the threshold (R7)
   assert_edge_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      edg_q <= EDGE_LAST);

   // A steady ripple line never moves the tally (R8)
   assert_quiet_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(active) && active && $stable(ripple) && $past(rip_q) == $past(ripple)
       && win_q != '0) |-> $stable(edg_q));

endmodule

// File: rtl/drv_seq_ctrl.sv
module drv_seq_ctrl
   import drv_seq_pkg::*;
#(
   parameter int CLK_KHZ     = 50000,
   parameter int RST_US      = 2,
   parameter int PRECHG_MS   = 400,
   parameter int PH_EDGES    = 6,
   parameter int PH_WIN_CYC  = 2000000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_req,
   input  logic stop_req,
   input  logic fault_clr,
   input  logic supply_ok,
   input  logic uv_flag,
   input  logic relay_fb,
   input  logic ripple,
   input  logic zero_ack,
   output logic latch_rst,
   output logic pwm_en,
   output logic zero_req,
   output logic mains_release,
   output logic fault_precharge,
   output logic fault_phase
);

   localparam int RST_CYC = (CLK_KHZ * RST_US + 999) / 1000;
   localparam int PRE_CYC = CLK_KHZ * PRECHG_MS;
   localparam int NSYNC   = 5;
   localparam logic [NSYNC-1:0] SYNC_RST = 5'b01010;

   generate
      if (CLK_KHZ < 1) begin : g_bad_clk
         $error("drv_seq_ctrl: CLK_KHZ must be positive");
      end
      if (RST_US < 1) begin : g_bad_rst
         $error("drv_seq_ctrl: reset pulse must be at least 1 us");
      end
      if (PRECHG_MS < 1) begin : g_bad_pre
         $error("drv_seq_ctrl: precharge budget must be positive");
      end
   endgenerate

   // ---------------- status input conditioning ----------------
   logic [NSYNC-1:0] raw_in, syn_in;
   logic supply_s, uv_s, relay_s, ripple_s, zack_s;

   assign raw_in = {supply_ok, uv_flag, relay_fb, ripple, zero_ack};

   drv_seq_sync #(
      .W       (NSYNC),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SYNC_RST)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (syn_in)
   );

   assign {supply_s, uv_s, relay_s, ripple_s, zack_s} = syn_in;

   logic ready;
   assign ready = supply_s && !uv_s && relay_s;

   // ---------------- state and helpers ----------------
   seq_state_t state_q, state_d;
   logic pulse_done, pre_tmo, ph_lost;
   logic fault_pre_q, fault_ph_q, fault_any;
   logic set_pre, set_ph;
   logic done_q, done_d;
   logic rel_q;

   assign fault_any = fault_pre_q || fault_ph_q;

   drv_seq_timer #(.LIMIT(RST_CYC)) u_pulse_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (state_q == ST_PULSE),
      .expire (pulse_done)
   );

   drv_seq_timer #(.LIMIT(PRE_CYC)) u_prechg_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     ((state_q == ST_WAIT) || (state_q == ST_PULSE)),
      .expire (pre_tmo)
   );

   drv_seq_phase_mon #(
      .EDGES   (PH_EDGES),
      .WIN_CYC (PH_WIN_CYC)
   ) u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .active     (state_q != ST_IDLE),
      .ripple     (ripple_s),
      .phase_lost (ph_lost)
   );

   // ---------------- next-state logic ----------------
   always_comb begin
      state_d = state_q;
      set_pre = 1'b0;
      set_ph  = 1'b0;
      done_d  = done_q;
      unique case (state_q)
         ST_IDLE: begin
            if (start_req && !fault_any) begin
               state_d = ST_WAIT;
               done_d  = 1'b0;
            end
         end
         ST_WAIT: begin
            if (stop_req) begin
               state_d = ST_IDLE;
            end else if (ph_lost) begin
               state_d = ST_IDLE;
               set_ph  = 1'b1;
            end else if (ready) begin
               state_d = ST_PULSE;
            end else if (pre_tmo) begin
               state_d = ST_IDLE;
               set_pre = 1'b1;
            end
         end
         ST_PULSE: begin
            if (ph_lost) begin
               state_d = ST_IDLE;
               set_ph  = 1'b1;
            end else if (!ready) begin
               state_d = ST_WAIT;
            end else if (pulse_done) begin
               state_d = ST_RUN;
            end
         end
         ST_RUN: begin
            if (ph_lost) begin
               state_d = ST_IDLE;
               set_ph  = 1'b1;
            end else if (!relay_s) begin
               state_d = ST_WAIT;
            end else if (stop_req) begin
               state_d = ST_STOP;
            end
         end
         ST_STOP: begin
            if (ph_lost) begin
               state_d = ST_IDLE;
               set_ph  = 1'b1;
            end else if (zack_s || !relay_s) begin
               state_d = ST_IDLE;
               done_d  = 1'b1;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   // ---------------- registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done_q  <= 1'b0;
         rel_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= done_d;
         rel_q   <= (state_d == ST_IDLE) && done_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_pre_q <= 1'b0;
         fault_ph_q  <= 1'b0;
      end else begin
         if (fault_clr) begin
            fault_pre_q <= 1'b0;
            fault_ph_q  <= 1'b0;
         end
         if (set_pre) fault_pre_q <= 1'b1;
         if (set_ph)  fault_ph_q  <= 1'b1;
      end
   end

   // ---------------- outputs ----------------
   assign latch_rst       = (state_q == ST_PULSE);
   assign pwm_en          = ((state_q == ST_RUN) || (state_q == ST_STOP)) && relay_s;
   assign zero_req        = (state_q == ST_STOP);
   assign mains_release   = rel_q;
   assign fault_precharge = fault_pre_q;
   assign fault_phase     = fault_ph_q;

   // ---------------- assertions ----------------
   // Run is entered only at the end of a reset pulse (R3)
   assert_run_after_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && $past(state_q) != ST_RUN) |-> $past(state_q) == ST_PULSE);

   // A pulse starts only from a cycle where all readiness inputs held (R2)
   assert_pulse_needs_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PULSE && $past(state_q) == ST_WAIT) |-> $past(ready));

   // Relay loss in run leaves the run state on the next edge (R5)
   assert_relay_loss_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state_q) == ST_RUN && !$past(relay_s)) |-> state_q != ST_RUN);

   // Precharge fault only raised out of the waiting state (R6)
   assert_timeout_origin_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_pre_q) |-> $past(state_q) == ST_WAIT);

   // Release to disconnect mains only with the drive idle and PWM off (R9)
   assert_release_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mains_release |-> (state_q == ST_IDLE && !pwm_en));

   // A set fault keeps the controller in idle (R10)
   assert_fault_holds_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(fault_any) && $past(state_q) == ST_IDLE) |-> state_q == ST_IDLE);

endmodule

// File: tb/drv_seq_ctrl_bench.sv
module drv_seq_ctrl_bench;

   localparam int CLK_PERIOD = 10;
   localparam int CLK_KHZ    = 1000;
   localparam int RST_US     = 3;
   localparam int PRECHG_MS  = 1;
   localparam int PH_EDGES   = 4;
   localparam int PH_WIN     = 64;
   localparam int RST_CYC    = 3;     // ceil(1000*3/1000)
   localparam int PRE_CYC    = 1000;  // 1000 * 1

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_req = 0, stop_req = 0, fault_clr = 0;
   logic supply_ok = 0, uv_flag = 1, relay_fb = 0, ripple = 1, zero_ack = 0;
   logic latch_rst, pwm_en, zero_req, mains_release, fault_precharge, fault_phase;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   drv_seq_ctrl #(
      .CLK_KHZ     (CLK_KHZ),
      .RST_US      (RST_US),
      .PRECHG_MS   (PRECHG_MS),
      .PH_EDGES    (PH_EDGES),
      .PH_WIN_CYC  (PH_WIN),
      .SYNC_STAGES (0)
   ) u_drv_seq_ctrl (
      .clk             (clk),
      .rst_n           (rst_n),
      .start_req       (start_req),
      .stop_req        (stop_req),
      .fault_clr       (fault_clr),
      .supply_ok       (supply_ok),
      .uv_flag         (uv_flag),
      .relay_fb        (relay_fb),
      .ripple          (ripple),
      .zero_ack        (zero_ack),
      .latch_rst       (latch_rst),
      .pwm_en          (pwm_en),
      .zero_req        (zero_req),
      .mains_release   (mains_release),
      .fault_precharge (fault_precharge),
      .fault_phase     (fault_phase)
   );

   task automatic tick(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic set_ready(input logic s, input logic u, input logic r);
      supply_ok = s; uv_flag = u; relay_fb = r;
   endtask

   task automatic do_start();
      start_req = 1'b1;
      tick();
      start_req = 1'b0;
   endtask

   // Start from idle with readiness absent, then go through a full pulse into run
   task automatic bring_up(input string req);
      do_start();
      chk(req, "latch before ready", latch_rst, 1'b0);
      set_ready(1, 0, 1);
      tick();
      for (int i = 0; i < RST_CYC; i++) begin
         chk(req, "latch during pulse", latch_rst, 1'b1);
         chk(req, "pwm during pulse", pwm_en, 1'b0);
         tick();
      end
      chk(req, "latch after pulse", latch_rst, 1'b0);
      chk(req, "pwm after pulse", pwm_en, 1'b1);
   endtask

   task automatic t_reset_state();
      chk("R1", "latch_rst", latch_rst, 1'b0);
      chk("R1", "pwm_en", pwm_en, 1'b0);
      chk("R1", "zero_req", zero_req, 1'b0);
      chk("R1", "mains_release", mains_release, 1'b0);
      chk("R1", "fault_precharge", fault_precharge, 1'b0);
      chk("R1", "fault_phase", fault_phase, 1'b0);
   endtask

   // R2 partial readiness, R11 stop while waiting
   task automatic t_partial_and_wait_stop();
      do_start();
      set_ready(1, 0, 0); tick(3);
      chk("R2", "latch without relay", latch_rst, 1'b0);
      set_ready(0, 0, 1); tick(3);
      chk("R2", "latch without supply", latch_rst, 1'b0);
      set_ready(1, 1, 1); tick(3);
      chk("R2", "latch under undervoltage", latch_rst, 1'b0);
      set_ready(1, 1, 0);
      stop_req = 1'b1; tick(); stop_req = 1'b0;
      set_ready(1, 0, 1); tick(3);
      chk("R11", "no pulse after stop in wait", latch_rst, 1'b0);
      chk("R11", "no release after stop in wait", mains_release, 1'b0);
      chk("R11", "pwm stays off", pwm_en, 1'b0);
      set_ready(0, 1, 0); tick();
   endtask

   // R4: readiness lost mid-pulse
   task automatic t_pulse_abort();
      do_start();
      set_ready(1, 0, 1);
      tick();
      chk("R4", "pulse started", latch_rst, 1'b1);
      uv_flag = 1'b1;
      tick();
      chk("R4", "latch after abort", latch_rst, 1'b0);
      chk("R4", "pwm after abort", pwm_en, 1'b0);
      tick(4);
      chk("R4", "latch while not ready", latch_rst, 1'b0);
      uv_flag = 1'b0;
      tick();
      for (int i = 0; i < RST_CYC; i++) begin
         chk("R4", "fresh pulse high", latch_rst, 1'b1);
         tick();
      end
      chk("R4", "run after fresh pulse", pwm_en, 1'b1);
   endtask

   // R5: relay feedback lost while running
   task automatic t_relay_loss();
      relay_fb = 1'b0;
      #1;
      chk("R5", "pwm same cycle", pwm_en, 1'b0);
      tick();
      chk("R5", "pwm after edge", pwm_en, 1'b0);
      chk("R5", "no latch while relay open", latch_rst, 1'b0);
      relay_fb = 1'b1;
      tick();
      chk("R5", "new pulse required", latch_rst, 1'b1);
      chk("R5", "pwm held off during pulse", pwm_en, 1'b0);
      tick(RST_CYC);
      chk("R5", "pwm back after pulse", pwm_en, 1'b1);
   endtask

   // R9: orderly stop
   task automatic t_orderly_stop();
      stop_req = 1'b1; tick(); stop_req = 1'b0;
      chk("R9", "zero_req raised", zero_req, 1'b1);
      chk("R9", "pwm kept for decel", pwm_en, 1'b1);
      tick(3);
      chk("R9", "still decelerating", pwm_en, 1'b1);
      chk("R9", "no early release", mains_release, 1'b0);
      zero_ack = 1'b1;
      tick();
      chk("R9", "pwm off after ack", pwm_en, 1'b0);
      chk("R9", "zero_req off after ack", zero_req, 1'b0);
      chk("R9", "release not yet", mains_release, 1'b0);
      tick();
      chk("R9", "release raised", mains_release, 1'b1);
      zero_ack = 1'b0;
      set_ready(0, 1, 0);
      tick(3);
      chk("R9", "release held", mains_release, 1'b1);
      do_start();
      chk("R9", "release cleared by start", mains_release, 1'b0);
      stop_req = 1'b1; tick(); stop_req = 1'b0;
   endtask

   // R6 timeout, R10 fault blocks start and clears
   task automatic t_precharge_timeout();
      do_start();
      tick(PRE_CYC - 5);
      chk("R6", "no fault before budget", fault_precharge, 1'b0);
      tick(10);
      chk("R6", "fault after budget", fault_precharge, 1'b1);
      chk("R6", "pwm off on timeout", pwm_en, 1'b0);
      set_ready(1, 0, 1);
      do_start();
      tick(2);
      chk("R10", "start ignored under fault", latch_rst, 1'b0);
      chk("R10", "pwm off under fault", pwm_en, 1'b0);
      set_ready(0, 1, 0);
      fault_clr = 1'b1; tick(); fault_clr = 1'b0;
      chk("R10", "precharge fault cleared", fault_precharge, 1'b0);
   endtask

   task automatic toggle_ripple(input int n);
      for (int i = 0; i < n; i++) begin
         ripple = ~ripple;
         tick();
      end
   endtask

   // R8: bursts below threshold, separated by more than one window
   task automatic t_phase_quiet();
      tick(PH_WIN + 6);
      toggle_ripple(PH_EDGES - 1);
      tick(PH_WIN + 6);
      toggle_ripple(PH_EDGES - 1);
      chk("R8", "no phase fault", fault_phase, 1'b0);
      chk("R8", "pwm still on", pwm_en, 1'b1);
      ripple = 1'b0;
      tick(PH_WIN + 6);
   endtask

   // R7: sustained toggling trips the phase-loss fault
   task automatic t_phase_loss();
      int seen = 0;
      for (int i = 0; i < 2 * PH_EDGES; i++) begin
         if (seen == 0) begin
            chk("R7", "pwm on before trip", pwm_en, 1'b1);
            ripple = ~ripple;
            tick();
            if (fault_phase) seen = i + 1;
         end
      end
      n_vec++;
      if (seen < PH_EDGES) begin
         n_bad++;
         $display("FAIL R7 edges to trip: actual %0d expected %0d..%0d", seen, PH_EDGES, 2 * PH_EDGES);
      end
      chk("R7", "pwm dropped on phase loss", pwm_en, 1'b0);
      ripple = 1'b0;
      set_ready(0, 1, 0);
      do_start();
      chk("R10", "start ignored with phase fault", fault_phase, 1'b1);
      fault_clr = 1'b1; tick(); fault_clr = 1'b0;
      chk("R10", "phase fault cleared", fault_phase, 1'b0);
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      ripple = 1'b0;
      tick();
      t_reset_state();
      t_partial_and_wait_stop();
      t_pulse_abort();
      t_relay_loss();
      t_orderly_stop();
      t_precharge_timeout();
      bring_up("R3");
      t_phase_quiet();
      t_phase_loss();
      if (!done) begin
         done = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule